// File: doc/BRIEF.md
# Cache access latency calculator

This block estimates how many clock cycles one access to a second-level cache takes. Software programs six cycle costs: reading and writing the tag array, reading and writing the dirty-flag array, and reading and writing the data array. Each request describes one access with five flags: read or write, hit or miss, whether the line to be replaced is dirty, whether writes go straight through to memory, and whether a write miss allocates a line. The request also carries the read and write latencies that the external memory reports. The block adds up the phases that this kind of access goes through and returns the total as one lumped latency.

A request is accepted on a valid/ready handshake. The block registers the total on `lat_o` and loads it into a down-counter. While the counter is nonzero, `ready_o` stays low. When the counter reaches zero, `done_o` pulses for one cycle. A model of the system can therefore stall a requester for exactly the estimated time. The tag, dirty and data arrays themselves are not modelled.

Top module: `cache_lat_calc`

## Requirements
- R1: Six 8-bit cost registers are at configuration addresses 0 (tag read), 1 (tag write), 2 (dirty read), 3 (dirty write), 4 (data read) and 5 (data write). Each resets to 1. A write with `cfg_we_i` high updates the register at the next clock edge. `cfg_rdata_o` combinationally shows the register selected by `cfg_addr_i`. Addresses 6 and 7 read as 0, and writes to them have no effect.
- R2: A read hit costs tag read + data read. The dirty flag and the allocate flag have no effect on it.
- R3: A read miss with a clean victim costs tag read + dirty read + external read + data write + tag write.
- R4: A read miss with a dirty victim costs tag read + dirty read + data read + external write + dirty write + external read + data write + tag write. With costs 2/2/1/1/8/8 and external latencies read 11 and write 8, this is 41.
- R5: A write hit with write-through off costs tag read + data write + dirty write. The dirty flag has no effect on it.
- R6: A write hit with write-through on costs tag read + data write + data read + external write + dirty write.
- R7: A write miss with allocate off costs tag read + external write. The dirty flag and the write-through flag have no effect on it.
- R8: A write miss with allocate on and a clean victim costs tag read + dirty read + external read + data write + tag write + data write + dirty write.
- R9: A write miss with allocate on and a dirty victim costs the R8 total plus data read + external write + dirty write.
- R10: A request is accepted when `req_valid_i` and `req_ready_o` are both high at a clock edge. `lat_o` takes the computed total at that edge and holds it until the next acceptance. `lat_o` is 12 bits wide, which holds every total without overflow.
- R11: After an acceptance with total L > 0, `req_ready_o` is low for exactly L cycles. `done_o` is high for one cycle, starting at the edge L edges after the accepting edge, and `req_ready_o` returns high in that same cycle. A total of 0 gives `done_o` in the cycle right after the accepting edge, and `req_ready_o` stays high.
- R12: During and after reset, `req_ready_o` is 1, `done_o` is 0 and `lat_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Cost register write enable |
| cfg_addr_i | input | 3 | Cost register address |
| cfg_wdata_i | input | 8 | Cost register write data |
| cfg_rdata_o | output | 8 | Cost register read data |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Ready to accept a request |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| req_hit_i | input | 1 | 1 = cache hit |
| req_dirty_i | input | 1 | Victim line is dirty |
| req_wthru_i | input | 1 | Write-through mode (1) or write-back mode (0) |
| req_walloc_i | input | 1 | Allocate a line on a write miss |
| ext_rd_lat_i | input | 8 | External memory read latency |
| ext_wr_lat_i | input | 8 | External memory write latency |
| lat_o | output | 12 | Lumped latency of the last accepted request |
| done_o | output | 1 | One-cycle pulse when the countdown ends |

## Verification
A wrong term in the scenario sum shows up on `lat_o` on the first cycle after the acceptance that selects that scenario. The bench therefore runs every scenario with costs distinct enough that a swapped or missing term changes the total. A corrupted down-counter shows up as `req_ready_o` or `done_o` toggling one or more cycles early or late. Both are compared on every clock against a behavioural model, so the error is caught within the cycle it occurs. A bad register decode appears at once on `cfg_rdata_o`, and later as a wrong total.

// File: rtl/cache_lat_pkg.sv
package cache_lat_pkg;
  localparam int unsigned PW   = 8;
  localparam int unsigned LW   = 12;
  localparam int unsigned AW   = 3;
  localparam int unsigned NPAR = 6;

  typedef enum logic [AW-1:0] {
    P_TAG_RD   = 3'd0,
    P_TAG_WR   = 3'd1,
    P_DIRTY_RD = 3'd2,
    P_DIRTY_WR = 3'd3,
    P_DATA_RD  = 3'd4,
    P_DATA_WR  = 3'd5
  } par_idx_e;

  typedef struct packed {
    logic write;
    logic hit;
    logic dirty;
    logic wthru;
    logic walloc;
  } req_t;
endpackage

// File: rtl/lat_param_regs.sv
module lat_param_regs #(
  parameter int unsigned PW      = cache_lat_pkg::PW,
  parameter int unsigned AW      = cache_lat_pkg::AW,
  parameter int unsigned NPAR    = cache_lat_pkg::NPAR,
  parameter int unsigned RST_VAL = 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [PW-1:0]            wdata_i,
  output logic [PW-1:0]            rdata_o,
  output logic [NPAR-1:0][PW-1:0]  par_o
);
  for (genvar g = 0; g < NPAR; g++) begin : g_reg
    localparam logic [AW-1:0] MY_ADDR = AW'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       par_o[g] <= PW'(RST_VAL);
      else if (we_i && addr_i == MY_ADDR) par_o[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NPAR; i++)
      if (addr_i == AW'(i)) rdata_o = par_o[i];
  end
endmodule

// File: rtl/lat_sum.sv
module lat_sum
  import cache_lat_pkg::*;
#(
  parameter int unsigned PW = cache_lat_pkg::PW,
  parameter int unsigned LW = cache_lat_pkg::LW
) (
  input  logic [NPAR-1:0][PW-1:0] par_i,
  input  req_t                    req_i,
  input  logic [PW-1:0]           ext_rd_i,
  input  logic [PW-1:0]           ext_wr_i,
  output logic [LW-1:0]           lat_o
);
  logic [LW-1:0] tr, tw, yr, yw, dr, dw, er, ew;
  logic refill, evict, rd_hit, wr_hit, wr_bypass;

  assign tr = LW'(par_i[P_TAG_RD]);
  assign tw = LW'(par_i[P_TAG_WR]);
  assign yr = LW'(par_i[P_DIRTY_RD]);
  assign yw = LW'(par_i[P_DIRTY_WR]);
  assign dr = LW'(par_i[P_DATA_RD]);
  assign dw = LW'(par_i[P_DATA_WR]);
  assign er = LW'(ext_rd_i);
  assign ew = LW'(ext_wr_i);

  // phase groups shared between scenarios
  assign rd_hit    = !req_i.write && req_i.hit;
  assign wr_hit    = req_i.write && req_i.hit;
  assign wr_bypass = req_i.write && !req_i.hit && !req_i.walloc;
  assign refill    = !req_i.hit && (!req_i.write || req_i.walloc);
  assign evict     = refill && req_i.dirty;

  always_comb begin
    lat_o = tr;
    if (rd_hit)                 lat_o += dr;
    if (wr_hit)                 lat_o += dw + yw;
    if (wr_hit && req_i.wthru)  lat_o += dr + ew;
    if (wr_bypass)              lat_o += ew;
    if (evict)                  lat_o += dr + ew + yw;
    if (refill)                 lat_o += yr + er + dw + tw;
    if (refill && req_i.write)  lat_o += dw + yw;
  end
endmodule

// File: rtl/lat_countdown.sv
module lat_countdown #(
  parameter int unsigned LW = cache_lat_pkg::LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [LW-1:0] lat_i,
  output logic          ready_o,
  output logic [LW-1:0] lat_o,
  output logic          done_o
);
  logic [LW-1:0] cnt_q;
  logic          take;

  assign ready_o = (cnt_q == '0);
  assign take    = valid_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lat_o  <= '0;
      done_o <= 1'b0;
    end else if (take) begin
      cnt_q  <= lat_i;
      lat_o  <= lat_i;
      done_o <= (lat_i == '0);
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - 1'b1;
      done_o <= (cnt_q == LW'(1));
    end else begin
      done_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cache_lat_calc.sv
module cache_lat_calc
  import cache_lat_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic [PW-1:0] cfg_wdata_i,
  output logic [PW-1:0] cfg_rdata_o,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic          req_hit_i,
  input  logic          req_dirty_i,
  input  logic          req_wthru_i,
  input  logic          req_walloc_i,
  input  logic [PW-1:0] ext_rd_lat_i,
  input  logic [PW-1:0] ext_wr_lat_i,
  output logic [LW-1:0] lat_o,
  output logic          done_o
);
  logic [NPAR-1:0][PW-1:0] par;
  logic [LW-1:0]           lat_calc;
  req_t                    req;

  assign req = '{write: req_write_i, hit: req_hit_i, dirty: req_dirty_i,
                 wthru: req_wthru_i, walloc: req_walloc_i};

  lat_param_regs #(.PW(PW), .AW(AW), .NPAR(NPAR), .RST_VAL(1)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .par_o   (par)
  );

  lat_sum #(.PW(PW), .LW(LW)) u_sum (
    .par_i    (par),
    .req_i    (req),
    .ext_rd_i (ext_rd_lat_i),
    .ext_wr_i (ext_wr_lat_i),
    .lat_o    (lat_calc)
  );

  lat_countdown #(.LW(LW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (req_valid_i),
    .lat_i   (lat_calc),
    .ready_o (req_ready_o),
    .lat_o   (lat_o),
    .done_o  (done_o)
  );
endmodule

// File: rtl/cache_lat_chk.sv
module cache_lat_chk #(
  parameter int unsigned PW   = cache_lat_pkg::PW,
  parameter int unsigned AW   = cache_lat_pkg::AW,
  parameter int unsigned LW   = cache_lat_pkg::LW,
  parameter int unsigned NPAR = cache_lat_pkg::NPAR
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_we_i,
  input logic [AW-1:0] cfg_addr_i,
  input logic [PW-1:0] cfg_wdata_i,
  input logic [PW-1:0] cfg_rdata_o,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic [LW-1:0] lat_o,
  input logic          done_o
);
  logic acc;
  assign acc = req_valid_i && req_ready_o;

  AST_CFG_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cfg_we_i) && $past(cfg_addr_i) < AW'(NPAR) && cfg_addr_i == $past(cfg_addr_i))
      |-> cfg_rdata_o == $past(cfg_wdata_i)); // R1

  AST_LAT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> $stable(lat_o)); // R10

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (lat_o == '0) || !req_ready_o); // R11

  AST_READY_RISE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_ready_o) |-> done_o); // R11

  AST_DONE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o); // R11

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !acc) |=> !done_o); // R11

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_STATE: assert (req_ready_o && !done_o && lat_o == '0); // R12
    end
  end
endmodule

bind cache_lat_calc cache_lat_chk #(
  .PW(cache_lat_pkg::PW), .AW(cache_lat_pkg::AW),
  .LW(cache_lat_pkg::LW), .NPAR(cache_lat_pkg::NPAR)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_addr_i  (cfg_addr_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_rdata_o (cfg_rdata_o),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .lat_o       (lat_o),
  .done_o      (done_o)
);

// File: tb/tb_cache_lat_calc.sv
module tb_cache_lat_calc;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0, req_hit = 1'b0, req_dirty = 1'b0;
  logic        req_wthru = 1'b0, req_walloc = 1'b0;
  logic [7:0]  ext_rd = '0, ext_wr = '0;
  logic [11:0] lat;
  logic        done;

  cache_lat_calc dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_hit_i(req_hit), .req_dirty_i(req_dirty),
    .req_wthru_i(req_wthru), .req_walloc_i(req_walloc),
    .ext_rd_lat_i(ext_rd), .ext_wr_lat_i(ext_wr),
    .lat_o(lat), .done_o(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // reference model state
  int    m_par[6];
  int    m_cnt, m_lat;
  bit    m_done;
  string m_tag = "R12";

  function automatic int ref_lat(bit w, bit h, bit d, bit wt, bit wa, int er, int ew);
    int tr = m_par[0], tw = m_par[1], yr = m_par[2];
    int yw = m_par[3], dr = m_par[4], dw = m_par[5];
    if (!w) begin
      if (h)  return tr + dr;
      if (!d) return tr + yr + er + dw + tw;
      return tr + yr + dr + ew + yw + er + dw + tw;
    end
    if (h) return wt ? tr + dw + dr + ew + yw : tr + dw + yw;
    if (!wa) return tr + ew;
    if (!d) return tr + yr + er + dw + tw + dw + yw;
    return tr + yr + dr + ew + yw + er + dw + tw + dw + yw;
  endfunction

  function automatic string scen_tag(bit w, bit h, bit d, bit wt, bit wa);
    if (!w) return h ? "R2" : (d ? "R4" : "R3");
    if (h) return wt ? "R6" : "R5";
    if (!wa) return "R7";
    return d ? "R9" : "R8";
  endfunction

  task automatic cmp(string tag, int act, int exp_v, string what);
    n_cmp++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp_v, $time);
    end
  endtask

  task automatic check_outputs();
    cmp("R11", int'(req_ready), (m_cnt == 0) ? 1 : 0, "ready");
    cmp("R11", int'(done), int'(m_done), "done");
    cmp(m_tag, int'(lat), m_lat, "lat");
    cmp("R1", int'(cfg_rdata), (cfg_addr < 6) ? m_par[cfg_addr] : 0, "rdata");
  endtask

  // model the coming edge with the inputs now driven, then step and compare
  task automatic tick();
    bit acc = req_valid && (m_cnt == 0);
    int l = ref_lat(req_write, req_hit, req_dirty, req_wthru, req_walloc,
                    int'(ext_rd), int'(ext_wr));
    if (acc) begin
      m_cnt = l; m_lat = l; m_done = (l == 0);
      m_tag = scen_tag(req_write, req_hit, req_dirty, req_wthru, req_walloc);
    end else if (m_cnt != 0) begin
      m_cnt--; m_done = (m_cnt == 0);
    end else m_done = 0;
    if (cfg_we && cfg_addr < 6) m_par[cfg_addr] = int'(cfg_wdata);
    @(posedge clk);
    @(negedge clk);
    check_outputs();
    cfg_we = 0;
    req_valid = 0;
  endtask

  task automatic cfg_write(int a, int v);
    cfg_we = 1; cfg_addr = 3'(a); cfg_wdata = 8'(v);
    tick();
  endtask

  task automatic request(bit w, bit h, bit d, bit wt, bit wa, int er, int ew);
    req_valid = 1; req_write = w; req_hit = h; req_dirty = d;
    req_wthru = wt; req_walloc = wa; ext_rd = 8'(er); ext_wr = 8'(ew);
    tick();
    while (m_cnt != 0) tick();
    tick();
  endtask

  task automatic all_scenarios(int er, int ew);
    request(0, 1, 0, 0, 0, er, ew); // R2
    request(0, 1, 1, 1, 1, er, ew); // R2 flags ignored
    request(0, 0, 0, 0, 0, er, ew); // R3
    request(0, 0, 1, 0, 1, er, ew); // R4
    request(1, 1, 0, 0, 0, er, ew); // R5
    request(1, 1, 1, 0, 1, er, ew); // R5 dirty ignored
    request(1, 1, 0, 1, 0, er, ew); // R6
    request(1, 0, 0, 0, 0, er, ew); // R7
    request(1, 0, 1, 1, 0, er, ew); // R7 dirty/wthru ignored
    request(1, 0, 0, 0, 1, er, ew); // R8
    request(1, 0, 1, 0, 1, er, ew); // R9
  endtask

  initial begin
    for (int i = 0; i < 6; i++) m_par[i] = 1;
    m_cnt = 0; m_lat = 0; m_done = 0;
    #(CLK_PERIOD*2 + 1);
    check_outputs(); // R12 during reset
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_outputs(); // R12 after release

    for (int a = 0; a < 8; a++) begin
      cfg_addr = 3'(a);
      #1 cmp("R1", int'(cfg_rdata), (a < 6) ? 1 : 0, "reset value");
    end

    all_scenarios(3, 5);             // default costs of 1

    cfg_write(0, 2); cfg_write(1, 2); cfg_write(2, 1);
    cfg_write(3, 1); cfg_write(4, 8); cfg_write(5, 8);
    cfg_write(6, 77); cfg_write(7, 99); // R1 ignored addresses
    for (int a = 0; a < 8; a++) begin
      cfg_addr = 3'(a);
      #1 cmp("R1", int'(cfg_rdata), (a < 6) ? m_par[a] : 0, "readback");
    end
    all_scenarios(11, 8);
    request(0, 0, 1, 0, 0, 11, 8);
    cmp("R4", int'(lat), 41, "example total");
    request(1, 0, 1, 0, 1, 11, 8);
    cmp("R9", int'(lat), 50, "example total");
    request(1, 0, 0, 0, 0, 11, 1);
    cmp("R7", int'(lat), 3, "example total");

    // distinct costs expose swapped terms
    cfg_write(0, 3); cfg_write(1, 5); cfg_write(2, 7);
    cfg_write(3, 11); cfg_write(4, 13); cfg_write(5, 17);
    all_scenarios(19, 23);

    // zero total: done on next cycle, ready stays high
    for (int i = 0; i < 6; i++) cfg_write(i, 0);
    request(0, 1, 0, 0, 0, 0, 0);   // R11 zero latency
    request(1, 0, 0, 0, 0, 0, 1);   // R11 latency 1
    req_valid = 1; req_write = 0; req_hit = 1; tick(); // back-to-back zero
    req_valid = 1; tick();
    tick();

    // maximum costs: widest total
    for (int i = 0; i < 6; i++) cfg_write(i, 255);
    request(1, 0, 1, 0, 1, 255, 255); // R9 / R10 no overflow
    cmp("R10", int'(lat), 2550, "max total");

    // request held during busy must be ignored until ready
    req_valid = 1; req_write = 0; req_hit = 1; tick();
    for (int k = 0; k < 5; k++) begin
      req_valid = 1; req_write = 1; req_hit = 0; req_walloc = 1; req_dirty = 1;
      tick();                          // R10 not accepted while busy
    end
    while (m_cnt != 0) tick();
    tick();

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule